// File: doc/BRIEF.md
# Grouped Bypass-Carry Adder

A combinational 32-bit binary adder. It takes two operands and a carry input and produces a 32-bit sum and a carry output. The word is cut into four bit groups whose widths need not be equal. Inside each group the carry ripples from bit to bit through full adders. The group also forms a propagate flag, which is the AND of the XOR of every operand bit pair in the group. When that flag is set, a multiplexer sends the group's incoming carry straight to the next group and the internal ripple is not used. Otherwise the rippled carry is passed on.

The group widths are a list in the package. The default, least significant group first, is 4, 6, 18 and 4 bits. A uniform list of four 8-bit groups is also provided, and the top module takes the list as a parameter. The external carry input feeds the lowest group, and the highest group's carry output is the external carry output. There is no state: the outputs follow the present inputs only.

Top module: `vskip_adder`

## Requirements
- R1: For every input, {co, sum} equals the 33-bit value of a_op + b_op + ci.
- R2: With the default list, the groups occupy bits [3:0], [9:4], [27:10] and [31:28]. With the uniform list of four 8-bit groups the adder must also meet R1.
- R3: When a_op XOR b_op is all ones, every group propagates. Then co equals ci, and every sum bit equals the inverse of ci.
- R4: When one group is fully propagating (a_op bits set, b_op bits clear inside it) and a carry is generated just below it, then its sum bits are all zero. The carry also arrives at the bit directly above it: sum bit 1, or co when the group is the top one.
- R5: With both operands zero, sum equals ci in bit 0 with zeros elsewhere, and co is 0.
- R6: With both operands all ones and ci = 1, sum is all ones and co is 1.
- R7: The outputs depend only on the current inputs. The same inputs give the same outputs whatever was applied before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_op | input | 32 | First operand |
| b_op | input | 32 | Second operand |
| ci | input | 1 | Carry input into the lowest group |
| sum | output | 32 | Sum bits |
| co | output | 1 | Carry output of the highest group |

## Verification
Every result is due in the same cycle as its stimulus, because the adder has no registers. The driver applies each vector just after a rising clock edge and queues the expected 33-bit value. The monitor pops and compares at the following falling edge, half a period later, when the inputs have been stable and the logic has settled. Two instances are checked side by side on the same vectors: one with the default unequal groups and one with uniform groups.

// File: rtl/vskip_pkg.sv
package vskip_pkg;
  localparam int WORD_W = 32;
  localparam int NGRP   = 4;

  typedef int grp_list_t [NGRP];

  // index 0 is the least significant group
  localparam grp_list_t VAR_WIDTHS = '{4, 6, 18, 4};
  localparam grp_list_t UNI_WIDTHS = '{8, 8, 8, 8};

  function automatic int grp_base(grp_list_t w, int g);
    int acc;
    acc = 0;
    for (int k = 0; k < g; k++) acc += w[k];
    return acc;
  endfunction
endpackage

// File: rtl/vskip_fa.sv
module vskip_fa (
  input  logic x,
  input  logic y,
  input  logic cin,
  output logic s,
  output logic cout
);
  always_comb begin
    s    = x ^ y ^ cin;
    cout = (x & y) | ((x | y) & cin);
  end
endmodule

// File: rtl/vskip_group.sv
module vskip_group #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         cout
);
  logic [W:0]   rc;
  logic [W-1:0] bit_p;
  logic         grp_p;

  assign rc[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    vskip_fa fa_i (
      .x    (x[i]),
      .y    (y[i]),
      .cin  (rc[i]),
      .s    (s[i]),
      .cout (rc[i+1])
    );
    assign bit_p[i] = x[i] ^ y[i];
  end

  assign grp_p = &bit_p;
  // bypass: a fully propagating group hands its carry-in straight on
  assign cout  = grp_p ? cin : rc[W];
endmodule

// File: rtl/vskip_adder.sv
module vskip_adder #(
  parameter vskip_pkg::grp_list_t GRP_W = vskip_pkg::VAR_WIDTHS
) (
  input  logic [vskip_pkg::WORD_W-1:0] a_op,
  input  logic [vskip_pkg::WORD_W-1:0] b_op,
  input  logic                         ci,
  output logic [vskip_pkg::WORD_W-1:0] sum,
  output logic                         co
);
  localparam int NG = vskip_pkg::NGRP;

  logic [NG:0] gc;

  assign gc[0] = ci;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    localparam int LO = vskip_pkg::grp_base(GRP_W, g);
    localparam int GW = GRP_W[g];
    vskip_group #(.W(GW)) grp_i (
      .x    (a_op[LO+GW-1:LO]),
      .y    (b_op[LO+GW-1:LO]),
      .cin  (gc[g]),
      .s    (sum[LO+GW-1:LO]),
      .cout (gc[g+1])
    );
  end

  assign co = gc[NG];
endmodule

// File: rtl/vskip_adder_chk.sv
module vskip_adder_chk (
  input logic [31:0] a_op,
  input logic [31:0] b_op,
  input logic        ci,
  input logic [31:0] sum,
  input logic        co
);
  always_comb begin
    // R1
    a_r1_exact_sum: assert ({co, sum} == ({1'b0, a_op} + {1'b0, b_op} + {32'd0, ci}))
      else $error("R1 sum mismatch");
    // R3
    if ((a_op ^ b_op) == 32'hFFFF_FFFF) begin
      a_r3_full_propagate: assert (co == ci && sum == {32{~ci}})
        else $error("R3 full propagate mismatch");
    end
    // R5
    if (a_op == 32'd0 && b_op == 32'd0) begin
      a_r5_zero_operands: assert (sum == {31'd0, ci} && !co)
        else $error("R5 zero operand mismatch");
    end
    // R6
    if (a_op == 32'hFFFF_FFFF && b_op == 32'hFFFF_FFFF && ci) begin
      a_r6_max_operands: assert (sum == 32'hFFFF_FFFF && co)
        else $error("R6 max operand mismatch");
    end
  end
endmodule

bind vskip_adder vskip_adder_chk chk_i (
  .a_op (a_op),
  .b_op (b_op),
  .ci   (ci),
  .sum  (sum),
  .co   (co)
);

// File: tb/vskip_adder_tb_top.sv
`timescale 1ns/1ps
module vskip_adder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] a_op = '0;
  logic [31:0] b_op = '0;
  logic        ci = 1'b0;
  logic [31:0] sum_v, sum_u;
  logic        co_v, co_u;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct {
    logic [32:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  always #5 clk = ~clk;

  vskip_adder dut_i (
    .a_op (a_op), .b_op (b_op), .ci (ci), .sum (sum_v), .co (co_v)
  );

  vskip_adder #(.GRP_W(vskip_pkg::UNI_WIDTHS)) dut_u (
    .a_op (a_op), .b_op (b_op), .ci (ci), .sum (sum_u), .co (co_u)
  );

  task automatic check(input string tag, input logic [32:0] act, input logic [32:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] ta, input logic [31:0] tb,
                       input logic tc, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    a_op = ta;
    b_op = tb;
    ci   = tc;
    it.exp = {1'b0, ta} + {1'b0, tb} + {32'd0, tc};
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: results are due in the same cycle, sampled at the falling edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(it.tag, {co_v, sum_v}, it.exp);
      check({it.tag, " uniform R2"}, {co_u, sum_u}, it.exp);
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int lo;
    int bases[5];
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state: zero inputs, R5
    check("R5 reset state", {co_v, sum_v}, 33'd0);

    drive(32'd0, 32'd0, 1'b1, "R5 zero operands ci=1");
    drive(32'd0, 32'd0, 1'b0, "R5 zero operands ci=0");
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R6 max operands");
    drive(32'hA5A5_A5A5, 32'h5A5A_5A5A, 1'b0, "R3 all propagate ci=0");
    drive(32'hA5A5_A5A5, 32'h5A5A_5A5A, 1'b1, "R3 all propagate ci=1");
    drive(32'hFFFF_FFFF, 32'd0, 1'b1, "R3 all ones plus carry");
    drive(32'hFFFF_FFFF, 32'd1, 1'b0, "R1 wrap to zero");
    drive(32'h8000_0000, 32'h8000_0000, 1'b0, "R1 top carry only");
    drive(32'h1234_5678, 32'h0FED_CBA9, 1'b1, "R1 mixed");

    // R4: each group fully propagating with a carry generated below it
    bases[0] = 0;
    for (int g = 0; g < 4; g++) bases[g+1] = bases[g] + vskip_pkg::VAR_WIDTHS[g];
    for (int g = 0; g < 4; g++) begin
      logic [31:0] m;
      logic [31:0] ta, tb;
      logic        tc;
      lo = bases[g];
      m  = '0;
      for (int k = lo; k < bases[g+1]; k++) m[k] = 1'b1;
      ta = m;
      tb = '0;
      tc = 1'b0;
      if (lo == 0) tc = 1'b1;
      else begin
        ta[lo-1] = 1'b1;
        tb[lo-1] = 1'b1;
      end
      drive(ta, tb, tc, "R4 group bypass");
      @(negedge clk);
      #1;
      n_checks++;
      if ((sum_v & m) !== 32'd0 ||
          ((bases[g+1] == 32) ? (co_v !== 1'b1) : (sum_v[bases[g+1]] !== 1'b1))) begin
        n_fail++;
        $display("FAIL R4 group %0d actual=%h/%b expected group zero, carry above", g, sum_v, co_v);
      end
    end

    // R2: carries across each uniform 8-bit boundary
    for (int g = 1; g < 4; g++)
      drive(32'd1 << (8*g - 1), 32'hFFFF_FFFF >> (32 - 8*g), 1'b0, "R2 uniform boundary");

    // R7: same inputs after different history
    drive(32'hDEAD_BEEF, 32'h1111_1111, 1'b1, "R7 first");
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R7 other");
    drive(32'hDEAD_BEEF, 32'h1111_1111, 1'b1, "R7 repeat");

    for (int i = 0; i < 400; i++)
      drive($urandom, $urandom, 1'($urandom), "R1 random");

    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule